// File: doc/BRIEF.md
# Multi-Mode Raster Timing Generator

This block turns a pixel-clock enable into the horizontal and vertical timing of a display raster. Two raster tables are built in: a 640x480 progressive table and a 640x200 low-resolution table, chosen at run time by a one-bit mode input. A separate two-bit line-mode input picks the polarity pair of the two sync outputs, and a panel downstream reads that pair to learn whether the picture has 480, 400 or 350 lines.

Every output is registered. The outputs describe the raster position that the internal counters hold in the same cycle: horizontal and vertical sync, a data-enable flag for the visible area, pixel coordinates inside that area, and one-cycle pulses that mark the start of each frame and of each line. The mode and line-mode inputs are sampled only when a frame wraps, so a raster is never cut short or mixed between tables. After reset the counters sit on the last dot of the last line. The first enabled dot therefore opens a fresh frame that uses whatever the inputs then select.

Top module: `vid_timing_gen`

## Requirements
- R1: During and after reset, with no enabled dot yet, de=0, pix_x=pix_y=0, frame_start=line_start=0 and hsync=vsync=1. The first enabled dot opens a frame: it pulses frame_start at position (0,0) and samples mode_sel and line_mode.
- R2: Counters move only in cycles with pix_en=1. In a cycle with pix_en=0, hsync, vsync, de, pix_x and pix_y hold their values and neither pulse is raised.
- R3: With mode_sel=0 a line is 800 dots: dots 0-639 are active, then 16 front-porch dots, 96 sync dots (656-751) and 48 back-porch dots. A frame is 525 lines: 480 active, then 11 front-porch lines, 2 sync lines (491-492) and 32 back-porch lines.
- R4: With mode_sel=1 a line is 912 dots: 640 active, then 95 front-porch dots, 64 sync dots (735-798) and 113 back-porch dots. A frame is 262 lines: 200 active, then 25 front-porch lines, 3 sync lines (225-227) and 34 back-porch lines.
- R5: line_mode selects the sync polarity. 0 (480 lines) gives a negative horizontal and a negative vertical sync. 1 (400 lines) gives a negative horizontal and a positive vertical sync. 2 (350 lines) gives a positive horizontal and a negative vertical sync. 3 acts as 0. A negative sync is low inside its sync range and high outside it; a positive sync is the reverse.
- R6: The line counter steps once per line, in the same cycle the dot counter wraps from its last dot to 0. vsync is active for every dot of the lines in the vertical sync range.
- R7: de is 1 only when both the dot and the line position are in their active ranges. Inside that area pix_x and pix_y equal the dot and the line position; outside it both are 0.
- R8: mode_sel and line_mode are sampled only on the enabled dot that wraps the last dot of the last line. Changes at any other time have no effect until then, and at that point both counters restart at 0.
- R9: frame_start is a one-cycle pulse that coincides with pixel (0,0) of each frame.
- R10: line_start is a one-cycle pulse that coincides with dot 0 of every line, visible or blank.
- R11: All outputs come from registers and describe the position the counters hold in that cycle. They change on the clock edge at which pix_en=1 is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Dot enable; one raster dot per cycle in which it is high |
| mode_sel | input | 1 | Raster table: 0 = 640x480, 1 = 640x200 |
| line_mode | input | 2 | Sync polarity pair: 0 = 480, 1 = 400, 2 = 350, 3 = as 0 |
| hsync | output | 1 | Horizontal sync at the selected polarity |
| vsync | output | 1 | Vertical sync at the selected polarity |
| de | output | 1 | High inside the visible area |
| pix_x | output | CNT_W | Dot coordinate inside the visible area, 0 elsewhere |
| pix_y | output | CNT_W | Line coordinate inside the visible area, 0 elsewhere |
| frame_start | output | 1 | One-cycle pulse at pixel (0,0) |
| line_start | output | 1 | One-cycle pulse at dot 0 of each line |

## Verification
The embedded properties watch some invariants on every cycle. A frame pulse always lands on the origin with de high, coordinates are zero outside the visible area, and the sampled table changes only together with a frame pulse. The line counter moves only with a line pulse, an idle cycle freezes the outputs, and neither counter passes its limit. The exact dot and line where each porch and sync region begins, the polarity pair for each line-mode code, and a deferred table switch landing on the right frame are shown only by the scenarios. In those scenarios an independent raster model predicts every output cycle by cycle. The bench runs both the built-in tables and a reduced pair of tables, so that whole frames and mode switches fit the run.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int CNT_W = 10;
    localparam int AXW   = 16;

    // One axis of a raster: active span followed by front porch, sync, back porch
    typedef struct packed {
        logic [AXW-1:0] act;
        logic [AXW-1:0] fp;
        logic [AXW-1:0] sync;
        logic [AXW-1:0] bp;
    } axis_t;

    typedef struct packed {
        axis_t h;
        axis_t v;
    } raster_t;

    localparam raster_t RASTER_VGA = '{
        h: '{16'd640, 16'd16, 16'd96, 16'd48},
        v: '{16'd480, 16'd11, 16'd2,  16'd32}
    };

    localparam raster_t RASTER_LOW = '{
        h: '{16'd640, 16'd95, 16'd64, 16'd113},
        v: '{16'd200, 16'd25, 16'd3,  16'd34}
    };

    typedef enum logic [1:0] {
        LINES_480  = 2'd0,
        LINES_400  = 2'd1,
        LINES_350  = 2'd2,
        LINES_ALT  = 2'd3
    } line_mode_e;

    function automatic int axis_total(axis_t a);
        return int'(a.act) + int'(a.fp) + int'(a.sync) + int'(a.bp);
    endfunction

    // Returns {horizontal negative, vertical negative}
    function automatic logic [1:0] sync_negative(logic [1:0] lm);
        case (line_mode_e'(lm))
            LINES_400: return 2'b10;
            LINES_350: return 2'b01;
            default:   return 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/vtg_counter.sv
module vtg_counter #(
    parameter int               CNT_W   = 10,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic [CNT_W-1:0] last_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic             wrap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = adv_i && (st_q.cnt == last_i);
        if (adv_i) begin
            st_d.cnt = wrap_o ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q_o = st_q.cnt;
    assign cnt_d_o = st_d.cnt;

    // R3 R4
    cnt_within_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q_o <= last_i);

    // R2
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(cnt_q_o));

endmodule

// File: rtl/vtg_region.sv
module vtg_region #(
    parameter int CNT_W = 10,
    parameter int AXW   = 16
) (
    input  logic [CNT_W-1:0] pos_i,
    input  logic [AXW-1:0]   act_len_i,
    input  logic [AXW-1:0]   fp_len_i,
    input  logic [AXW-1:0]   sync_len_i,
    output logic             act_o,
    output logic             sync_o
);

    int pos_w, sync_beg, sync_end;

    always_comb begin
        pos_w    = int'(pos_i);
        sync_beg = int'(act_len_i) + int'(fp_len_i);
        sync_end = sync_beg + int'(sync_len_i);
        act_o    = pos_w < int'(act_len_i);
        sync_o   = (pos_w >= sync_beg) && (pos_w < sync_end);
    end

endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
    import vtg_pkg::*;
#(
    parameter int      CNT_W    = vtg_pkg::CNT_W,
    parameter raster_t RASTER_A = vtg_pkg::RASTER_VGA,
    parameter raster_t RASTER_B = vtg_pkg::RASTER_LOW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic             mode_sel,
    input  logic [1:0]       line_mode,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [CNT_W-1:0] pix_x,
    output logic [CNT_W-1:0] pix_y,
    output logic             frame_start,
    output logic             line_start
);

    localparam logic [CNT_W-1:0] H_LAST_A = CNT_W'(axis_total(RASTER_A.h) - 1);
    localparam logic [CNT_W-1:0] V_LAST_A = CNT_W'(axis_total(RASTER_A.v) - 1);
    localparam logic [CNT_W-1:0] H_LAST_B = CNT_W'(axis_total(RASTER_B.h) - 1);
    localparam logic [CNT_W-1:0] V_LAST_B = CNT_W'(axis_total(RASTER_B.v) - 1);
    localparam int               N_AXES   = 2;

    typedef struct packed {
        logic             mode;
        logic             neg_h;
        logic             neg_v;
        logic             hsync;
        logic             vsync;
        logic             de;
        logic [CNT_W-1:0] x;
        logic [CNT_W-1:0] y;
        logic             fs;
        logic             ls;
    } tg_state_t;

    tg_state_t st_d, st_q;

    // Limits of the table in force
    logic [CNT_W-1:0] h_last, v_last;
    logic [CNT_W-1:0] h_cnt_q, h_cnt_d, v_cnt_q, v_cnt_d;
    logic             h_wrap, v_wrap;

    always_comb begin
        h_last = st_q.mode ? H_LAST_B : H_LAST_A;
        v_last = st_q.mode ? V_LAST_B : V_LAST_A;
    end

    vtg_counter #(.CNT_W(CNT_W), .RST_VAL(H_LAST_A)) u_hcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (pix_en),
        .last_i  (h_last),
        .cnt_q_o (h_cnt_q),
        .cnt_d_o (h_cnt_d),
        .wrap_o  (h_wrap)
    );

    vtg_counter #(.CNT_W(CNT_W), .RST_VAL(V_LAST_A)) u_vcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (h_wrap),
        .last_i  (v_last),
        .cnt_q_o (v_cnt_q),
        .cnt_d_o (v_cnt_d),
        .wrap_o  (v_wrap)
    );

    // Mode and polarity sampled only when the frame wraps
    logic       mode_n;
    logic [1:0] neg_n;

    always_comb begin
        mode_n = st_q.mode;
        neg_n  = {st_q.neg_h, st_q.neg_v};
        if (v_wrap) begin
            mode_n = mode_sel;
            neg_n  = sync_negative(line_mode);
        end
    end

    // Region decode of the next position, one instance per axis
    logic [CNT_W-1:0]   ax_pos  [N_AXES];
    logic [AXW-1:0]     ax_act  [N_AXES];
    logic [AXW-1:0]     ax_fp   [N_AXES];
    logic [AXW-1:0]     ax_sync [N_AXES];
    logic [N_AXES-1:0]  in_act, in_sync;
    raster_t            tbl_n;

    always_comb begin
        tbl_n      = mode_n ? RASTER_B : RASTER_A;
        ax_pos[0]  = h_cnt_d;
        ax_pos[1]  = v_cnt_d;
        ax_act[0]  = tbl_n.h.act;
        ax_fp[0]   = tbl_n.h.fp;
        ax_sync[0] = tbl_n.h.sync;
        ax_act[1]  = tbl_n.v.act;
        ax_fp[1]   = tbl_n.v.fp;
        ax_sync[1] = tbl_n.v.sync;
    end

    for (genvar g = 0; g < N_AXES; g++) begin : g_axis
        vtg_region #(.CNT_W(CNT_W), .AXW(AXW)) u_region (
            .pos_i      (ax_pos[g]),
            .act_len_i  (ax_act[g]),
            .fp_len_i   (ax_fp[g]),
            .sync_len_i (ax_sync[g]),
            .act_o      (in_act[g]),
            .sync_o     (in_sync[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.mode  = mode_n;
        st_d.neg_h = neg_n[1];
        st_d.neg_v = neg_n[0];
        st_d.hsync = in_sync[0] ^ neg_n[1];
        st_d.vsync = in_sync[1] ^ neg_n[0];
        st_d.de    = in_act[0] && in_act[1];
        st_d.x     = st_d.de ? h_cnt_d : '0;
        st_d.y     = st_d.de ? v_cnt_d : '0;
        st_d.fs    = v_wrap;
        st_d.ls    = h_wrap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode  <= 1'b0;
            st_q.neg_h <= 1'b1;
            st_q.neg_v <= 1'b1;
            st_q.hsync <= 1'b1;
            st_q.vsync <= 1'b1;
            st_q.de    <= 1'b0;
            st_q.x     <= '0;
            st_q.y     <= '0;
            st_q.fs    <= 1'b0;
            st_q.ls    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hsync       = st_q.hsync;
    assign vsync       = st_q.vsync;
    assign de          = st_q.de;
    assign pix_x       = st_q.x;
    assign pix_y       = st_q.y;
    assign frame_start = st_q.fs;
    assign line_start  = st_q.ls;

    // R9
    fs_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (de && pix_x == '0 && pix_y == '0));

    // R9
    fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R7
    blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> (pix_x == '0 && pix_y == '0));

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != $past(st_q.mode)) |-> frame_start);

    // R6
    v_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_cnt_q != $past(v_cnt_q)) |-> line_start);

    // R10
    ls_dot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> (h_cnt_q == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> ($stable({hsync, vsync, de, pix_x, pix_y}) && !frame_start && !line_start));

endmodule

// File: tb/vid_timing_gen_bench.sv
`timescale 1ns/1ps
module vid_timing_gen_bench;

    typedef struct packed {
        int ha; int hf; int hs; int hb;
        int va; int vf; int vs; int vb;
    } tbl_t;

    typedef struct packed {
        logic       hs;
        logic       vs;
        logic       de;
        logic       fs;
        logic       ls;
        logic [9:0] x;
        logic [9:0] y;
    } out_t;

    // Reduced tables for the second instance
    localparam vtg_pkg::raster_t MINI_A = '{
        h: '{16'd8, 16'd2, 16'd3, 16'd2},
        v: '{16'd4, 16'd1, 16'd2, 16'd1}
    };
    localparam vtg_pkg::raster_t MINI_B = '{
        h: '{16'd6, 16'd1, 16'd2, 16'd3},
        v: '{16'd3, 16'd2, 16'd1, 16'd2}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pix_en;
    logic       mode_sel;
    logic [1:0] line_mode;

    logic       d0_hs, d0_vs, d0_de, d0_fs, d0_ls;
    logic [9:0] d0_x, d0_y;
    logic       d1_hs, d1_vs, d1_de, d1_fs, d1_ls;
    logic [9:0] d1_x, d1_y;

    always #2 clk = ~clk;

    vid_timing_gen u_vid_timing_gen (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .mode_sel(mode_sel),
        .line_mode(line_mode), .hsync(d0_hs), .vsync(d0_vs), .de(d0_de),
        .pix_x(d0_x), .pix_y(d0_y), .frame_start(d0_fs), .line_start(d0_ls)
    );

    vid_timing_gen #(.CNT_W(10), .RASTER_A(MINI_A), .RASTER_B(MINI_B)) u_vid_timing_gen_mini (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .mode_sel(mode_sel),
        .line_mode(line_mode), .hsync(d1_hs), .vsync(d1_vs), .de(d1_de),
        .pix_x(d1_x), .pix_y(d1_y), .frame_start(d1_fs), .line_start(d1_ls)
    );

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R1";

    out_t  q0[$];
    out_t  q1[$];
    string rq[$];

    // Independent raster model
    int mh[2];
    int mv[2];
    bit mm[2];
    bit mnh[2];
    bit mnv[2];

    function automatic tbl_t get_tbl(int d, bit m);
        tbl_t t;
        if (d == 0) t = m ? '{640, 95, 64, 113, 200, 25, 3, 34}
                          : '{640, 16, 96, 48, 480, 11, 2, 32};
        else        t = m ? '{6, 1, 2, 3, 3, 2, 1, 2}
                          : '{8, 2, 3, 2, 4, 1, 2, 1};
        return t;
    endfunction

    function automatic void model_reset();
        for (int d = 0; d < 2; d++) begin
            tbl_t t = get_tbl(d, 1'b0);
            mm[d]  = 1'b0;
            mnh[d] = 1'b1;
            mnv[d] = 1'b1;
            mh[d]  = t.ha + t.hf + t.hs + t.hb - 1;
            mv[d]  = t.va + t.vf + t.vs + t.vb - 1;
        end
    endfunction

    function automatic out_t model_step(int d, bit pe, bit m, logic [1:0] lm);
        tbl_t t;
        out_t o;
        bit   fs = 1'b0;
        bit   ls = 1'b0;
        bit   hin, vin;
        t = get_tbl(d, mm[d]);
        if (pe) begin
            if (mh[d] == t.ha + t.hf + t.hs + t.hb - 1) begin
                mh[d] = 0;
                ls    = 1'b1;
                if (mv[d] == t.va + t.vf + t.vs + t.vb - 1) begin
                    mv[d] = 0;
                    fs    = 1'b1;
                    mm[d] = m;
                    mnh[d] = (lm != 2'd2);
                    mnv[d] = (lm != 2'd1);
                end else begin
                    mv[d] = mv[d] + 1;
                end
            end else begin
                mh[d] = mh[d] + 1;
            end
        end
        t    = get_tbl(d, mm[d]);
        hin  = (mh[d] >= t.ha + t.hf) && (mh[d] < t.ha + t.hf + t.hs);
        vin  = (mv[d] >= t.va + t.vf) && (mv[d] < t.va + t.vf + t.vs);
        o.hs = hin ^ mnh[d];
        o.vs = vin ^ mnv[d];
        o.de = (mh[d] < t.ha) && (mv[d] < t.va);
        o.x  = o.de ? 10'(mh[d]) : 10'd0;
        o.y  = o.de ? 10'(mv[d]) : 10'd0;
        o.fs = fs;
        o.ls = ls;
        return o;
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected result
    task automatic step(bit pe, bit m, logic [1:0] lm);
        @(negedge clk);
        pix_en    = pe;
        mode_sel  = m;
        line_mode = lm;
        q0.push_back(model_step(0, pe, m, lm));
        q1.push_back(model_step(1, pe, m, lm));
        rq.push_back(cur_req);
    endtask

    task automatic do_reset(bit m, logic [1:0] lm);
        @(negedge clk);
        rst_n     = 1'b0;
        pix_en    = 1'b0;
        mode_sel  = m;
        line_mode = lm;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic chk_val(string r, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s table value: actual %0d expected %0d", r, act, exp);
        end
    endtask

    task automatic compare(int d, out_t a, out_t e, string r);
        n_checks++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s dut%0d at %0t: actual hs=%b vs=%b de=%b fs=%b ls=%b x=%0d y=%0d expected hs=%b vs=%b de=%b fs=%b ls=%b x=%0d y=%0d",
                     r, d, $time, a.hs, a.vs, a.de, a.fs, a.ls, a.x, a.y,
                     e.hs, e.vs, e.de, e.fs, e.ls, e.x, e.y);
        end
    endtask

    // Monitor: pops one expected item per cycle, away from the edge
    always @(posedge clk) begin
        #1;
        if (q0.size() > 0) begin
            out_t  e0, e1, a0, a1;
            string r;
            e0 = q0.pop_front();
            e1 = q1.pop_front();
            r  = rq.pop_front();
            a0 = '{d0_hs, d0_vs, d0_de, d0_fs, d0_ls, d0_x, d0_y};
            a1 = '{d1_hs, d1_vs, d1_de, d1_fs, d1_ls, d1_x, d1_y};
            compare(0, a0, e0, r);
            compare(1, a1, e1, r);
        end
    end

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        rst_n     = 1'b0;
        pix_en    = 1'b0;
        mode_sel  = 1'b0;
        line_mode = 2'd0;

        // R3 and R4 built-in tables, including the vertical spans
        chk_val("R3", int'(vtg_pkg::RASTER_VGA.h.fp),   16);
        chk_val("R3", int'(vtg_pkg::RASTER_VGA.h.sync), 96);
        chk_val("R3", int'(vtg_pkg::RASTER_VGA.h.bp),   48);
        chk_val("R3", int'(vtg_pkg::RASTER_VGA.v.act),  480);
        chk_val("R3", int'(vtg_pkg::RASTER_VGA.v.fp),   11);
        chk_val("R3", int'(vtg_pkg::RASTER_VGA.v.sync), 2);
        chk_val("R3", int'(vtg_pkg::RASTER_VGA.v.bp),   32);
        chk_val("R4", int'(vtg_pkg::RASTER_LOW.h.fp),   95);
        chk_val("R4", int'(vtg_pkg::RASTER_LOW.h.sync), 64);
        chk_val("R4", int'(vtg_pkg::RASTER_LOW.h.bp),   113);
        chk_val("R4", int'(vtg_pkg::RASTER_LOW.v.act),  200);
        chk_val("R4", int'(vtg_pkg::RASTER_LOW.v.fp),   25);
        chk_val("R4", int'(vtg_pkg::RASTER_LOW.v.sync), 3);
        chk_val("R4", int'(vtg_pkg::RASTER_LOW.v.bp),   34);

        do_reset(1'b0, 2'd0);
        cur_req = "R1";
        repeat (3) step(1'b0, 1'b0, 2'd0);
        cur_req = "R9";
        step(1'b1, 1'b0, 2'd0);
        cur_req = "R3";
        for (int i = 0; i < 1700; i++) step(1'b1, 1'b0, 2'd0);
        cur_req = "R2";
        for (int i = 0; i < 400; i++) step(i % 3 != 0, 1'b0, 2'd0);
        cur_req = "R8";
        for (int i = 0; i < 300; i++) step(1'b1, i > 40, (i > 40) ? 2'd1 : 2'd0);

        cur_req = "R4";
        do_reset(1'b1, 2'd2);
        for (int i = 0; i < 1900; i++) step(1'b1, 1'b1, 2'd2);

        cur_req = "R5";
        for (int lm = 0; lm < 4; lm++) begin
            for (int m = 0; m < 2; m++) begin
                do_reset(m[0], lm[1:0]);
                for (int i = 0; i < 260; i++) step(1'b1, m[0], lm[1:0]);
            end
        end
        do_reset(1'b0, 2'd1);
        for (int i = 0; i < 820; i++) step(1'b1, 1'b0, 2'd1);

        cur_req = "R6";
        do_reset(1'b0, 2'd0);
        for (int i = 0; i < 1000; i++) step(i % 5 != 4, (i / 150) % 2 == 1, 2'(i % 4));

        cur_req = "R10";
        for (int i = 0; i < 400; i++) step(1'b1, (i / 97) % 2 == 0, 2'd0);

        cur_req = "R11";
        for (int i = 0; i < 200; i++) step(i % 2 == 0, 1'b1, 2'd2);

        @(negedge clk);
        @(negedge clk);
        report();
    end

endmodule